// File: doc/BRIEF.md
# Multicycle Bus Sequencer Core

This block is the control unit and datapath of a small 16-bit, word-addressed processor. All transfers between its registers pass over one shared bus. A state machine steps through instruction fetch, decode and one of three execute sequences. These are add (register or immediate operand), store to base-plus-offset and load from base-plus-offset. In every state it raises a fixed set of bus-gate and register-load strobes. The datapath holds the program counter, memory address and data registers, the instruction register, an eight-entry register file, an add-only ALU, an address adder and a three-bit condition-code register.

Memory sits outside the block. It samples `mem_addr`/`mem_wdata` on a clock edge when both `mem_en` and `mem_we` are high. It returns `mem_rdata` for the word at `mem_addr` in the same cycle. `fetch_start` marks the first cycle of every instruction, so a system can count instructions and their lengths.

Top module: `bus_seq_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to `START_ADDR`, puts the sequencer in the first fetch cycle (`fetch_start` high), sets `cc_nzp` to 3'b010 and clears all eight registers to zero.
- R2: Fetch takes three cycles. In the first, the PC is copied to the address register and the PC increments. In the second, `mem_en` is high with `mem_we` low and `mem_addr` equals the instruction's address. In the third, the read word moves into the instruction register. Consecutive instructions come from consecutive addresses.
- R3: At most one source drives the internal bus in any cycle.
- R4: Opcode 4'b0001 in IR[15:12] adds. DR=IR[11:9] and SR1=IR[8:6]. IR[5]=1 uses IR[4:0] sign-extended; IR[5]=0 uses register IR[2:0]. The instruction takes 5 cycles, fetch start to fetch start.
- R5: `cc_nzp` is {N,Z,P}, with exactly one bit set. Add and load set it from the value written (negative, zero, positive). Store and unknown opcodes leave it unchanged.
- R6: Opcode 4'b0111 stores register IR[11:9] at register IR[8:6] plus IR[5:0] sign-extended. It takes 7 cycles.
- R7: Opcode 4'b0110 loads the word at register IR[8:6] plus IR[5:0] sign-extended into register IR[11:9]. It takes 7 cycles.
- R8: Any other opcode changes no register, memory word or condition code, and fetch restarts after 4 cycles.
- R9: Addition wraps modulo 2^16.
- R10: `mem_we` is high only together with `mem_en`, and each store raises it for exactly one cycle. Fetch, add and load never write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | W | Word read at `mem_addr` |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write this cycle |
| mem_addr | output | W | Memory address (address register) |
| mem_wdata | output | W | Write data (data register) |
| cc_nzp | output | 3 | Condition codes {N,Z,P} |
| fetch_start | output | 1 | First cycle of an instruction |

## Verification
Negative immediates and offsets are used so that a design that zero-extends them would write to the wrong address or produce a wrong sign. A sum that wraps to zero checks that the carry is dropped and Z is set. Loads return both zero and negative words, so a condition-code path fed from the wrong source gives a wrong flag. Stores follow a flag-setting add to show that a store does not touch the flags. An unknown opcode, and a reset given in the middle of an instruction followed by a store of a register, catch a design that does not return cleanly to fetch or does not clear its register file.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int REG_AW = 3;

  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_LDR = 4'b0110;
  localparam logic [3:0] OPC_STR = 4'b0111;

  // bus source indices
  localparam int GATE_N    = 4;
  localparam int GATE_PC   = 0;
  localparam int GATE_ALU  = 1;
  localparam int GATE_ADDR = 2;
  localparam int GATE_MDR  = 3;

  typedef enum logic [3:0] {
    ST_FETCH_PC  = 4'd0,
    ST_FETCH_MEM = 4'd1,
    ST_FETCH_IR  = 4'd2,
    ST_DECODE    = 4'd3,
    ST_ADD       = 4'd4,
    ST_STR_ADDR  = 4'd5,
    ST_STR_DATA  = 4'd6,
    ST_STR_WRITE = 4'd7,
    ST_LDR_ADDR  = 4'd8,
    ST_LDR_READ  = 4'd9,
    ST_LDR_WB    = 4'd10
  } seq_state_e;

  typedef struct packed {
    logic [GATE_N-1:0] gate;
    logic ld_pc;
    logic ld_mar;
    logic ld_mdr;
    logic mdr_from_bus;
    logic ld_ir;
    logic ld_reg;
    logic ld_cc;
    logic mem_en;
    logic mem_we;
    logic alu_pass;
    logic sr1_from_dr;
  } seq_ctrl_t;

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  output seq_state_e state_o,
  output seq_ctrl_t  ctrl_o
);

  seq_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH_PC;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = ST_FETCH_PC;
    case (state_q)
      ST_FETCH_PC:  state_d = ST_FETCH_MEM;
      ST_FETCH_MEM: state_d = ST_FETCH_IR;
      ST_FETCH_IR:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OPC_ADD: state_d = ST_ADD;
          OPC_STR: state_d = ST_STR_ADDR;
          OPC_LDR: state_d = ST_LDR_ADDR;
          default: state_d = ST_FETCH_PC;
        endcase
      end
      ST_STR_ADDR:  state_d = ST_STR_DATA;
      ST_STR_DATA:  state_d = ST_STR_WRITE;
      ST_LDR_ADDR:  state_d = ST_LDR_READ;
      ST_LDR_READ:  state_d = ST_LDR_WB;
      default:      state_d = ST_FETCH_PC;
    endcase
  end

  always_comb begin
    ctrl_o = '0;
    case (state_q)
      ST_FETCH_PC: begin
        ctrl_o.gate[GATE_PC] = 1'b1;
        ctrl_o.ld_mar        = 1'b1;
        ctrl_o.ld_pc         = 1'b1;
      end
      ST_FETCH_MEM, ST_LDR_READ: begin
        ctrl_o.mem_en = 1'b1;
        ctrl_o.ld_mdr = 1'b1;
      end
      ST_FETCH_IR: begin
        ctrl_o.gate[GATE_MDR] = 1'b1;
        ctrl_o.ld_ir          = 1'b1;
      end
      ST_ADD: begin
        ctrl_o.gate[GATE_ALU] = 1'b1;
        ctrl_o.ld_reg         = 1'b1;
        ctrl_o.ld_cc          = 1'b1;
      end
      ST_STR_ADDR, ST_LDR_ADDR: begin
        ctrl_o.gate[GATE_ADDR] = 1'b1;
        ctrl_o.ld_mar          = 1'b1;
      end
      ST_STR_DATA: begin
        ctrl_o.sr1_from_dr    = 1'b1;
        ctrl_o.alu_pass       = 1'b1;
        ctrl_o.gate[GATE_ALU] = 1'b1;
        ctrl_o.ld_mdr         = 1'b1;
        ctrl_o.mdr_from_bus   = 1'b1;
      end
      ST_STR_WRITE: begin
        ctrl_o.mem_en = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end
      ST_LDR_WB: begin
        ctrl_o.gate[GATE_MDR] = 1'b1;
        ctrl_o.ld_reg         = 1'b1;
        ctrl_o.ld_cc          = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end

  assign state_o = state_q;

endmodule

// File: rtl/bus_seq_regfile.sv
module bus_seq_regfile #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  localparam int N = 1 << AW;

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/bus_seq_dp.sv
module bus_seq_dp
  import bus_seq_pkg::*;
#(
  parameter int          W          = 16,
  parameter logic [15:0] START_ADDR = 16'h0000
) (
  input  logic         clk,
  input  logic         rst,
  input  seq_ctrl_t    ctrl,
  input  logic [W-1:0] rf_a,
  input  logic [W-1:0] rf_b,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] bus_o,
  output logic [15:0]  ir_o,
  output logic [W-1:0] pc_o,
  output logic [W-1:0] mar_o,
  output logic [W-1:0] mdr_o,
  output logic [2:0]   cc_o
);

  logic [W-1:0] pc_q, mar_q, mdr_q;
  logic [15:0]  ir_q;
  logic [2:0]   cc_q;
  logic [W-1:0] sext5, sext6, alu_b, alu_y, addr_y;
  logic [W-1:0] src [GATE_N];
  logic [W-1:0] bus;
  logic         neg, zero;

  assign sext5  = {{(W-5){ir_q[4]}}, ir_q[4:0]};
  assign sext6  = {{(W-6){ir_q[5]}}, ir_q[5:0]};
  assign alu_b  = ir_q[5] ? sext5 : rf_b;
  assign alu_y  = ctrl.alu_pass ? rf_a : (rf_a + alu_b);
  assign addr_y = rf_a + sext6;

  always_comb begin
    src[GATE_PC]   = pc_q;
    src[GATE_ALU]  = alu_y;
    src[GATE_ADDR] = addr_y;
    src[GATE_MDR]  = mdr_q;
  end

  // bus: gated OR of the sources
  always_comb begin
    bus = '0;
    for (int g = 0; g < GATE_N; g++) begin
      if (ctrl.gate[g]) bus = bus | src[g];
    end
  end

  assign neg  = bus[W-1];
  assign zero = (bus == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= W'(START_ADDR);
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      cc_q  <= 3'b010;
    end else begin
      if (ctrl.ld_pc)  pc_q  <= pc_q + 1'b1;
      if (ctrl.ld_mar) mar_q <= bus;
      if (ctrl.ld_mdr) mdr_q <= ctrl.mdr_from_bus ? bus : mem_rdata;
      if (ctrl.ld_ir)  ir_q  <= bus[15:0];
      if (ctrl.ld_cc)  cc_q  <= {neg, zero, ~neg & ~zero};
    end
  end

  assign bus_o = bus;
  assign ir_o  = ir_q;
  assign pc_o  = pc_q;
  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign cc_o  = cc_q;

endmodule

// File: rtl/bus_seq_core.sv
module bus_seq_core
  import bus_seq_pkg::*;
#(
  parameter int          W          = 16,
  parameter logic [15:0] START_ADDR = 16'h0000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_en,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [2:0]   cc_nzp,
  output logic         fetch_start
);

  seq_state_e   state;
  seq_ctrl_t    ctrl;
  logic [15:0]  ir;
  logic [W-1:0] bus, pc, mar, mdr, rf_a, rf_b;
  logic [2:0]   cc;
  logic [REG_AW-1:0] ra_sel;

  bus_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .opcode  (ir[15:12]),
    .state_o (state),
    .ctrl_o  (ctrl)
  );

  assign ra_sel = ctrl.sr1_from_dr ? ir[11:9] : ir[8:6];

  bus_seq_regfile #(.W(W), .AW(REG_AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl.ld_reg),
    .waddr   (ir[11:9]),
    .wdata   (bus),
    .raddr_a (ra_sel),
    .raddr_b (ir[2:0]),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  bus_seq_dp #(.W(W), .START_ADDR(START_ADDR)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .rf_a      (rf_a),
    .rf_b      (rf_b),
    .mem_rdata (mem_rdata),
    .bus_o     (bus),
    .ir_o      (ir),
    .pc_o      (pc),
    .mar_o     (mar),
    .mdr_o     (mdr),
    .cc_o      (cc)
  );

  assign mem_en      = ctrl.mem_en;
  assign mem_we      = ctrl.mem_we;
  assign mem_addr    = mar;
  assign mem_wdata   = mdr;
  assign cc_nzp      = cc;
  assign fetch_start = (state == ST_FETCH_PC);

endmodule

// File: rtl/bus_seq_core_chk.sv
module bus_seq_core_chk
  import bus_seq_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input seq_ctrl_t    ctrl,
  input seq_state_e   state,
  input logic [W-1:0] pc,
  input logic [W-1:0] mar,
  input logic [2:0]   cc,
  input logic         mem_en,
  input logic         mem_we
);

  p_one_gate_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl.gate));

  p_cc_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(cc) == 1);

  p_cc_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.ld_cc |=> $stable(cc));

  p_fetch_pc_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH_PC |=> (mar == $past(pc)) && (pc == W'($past(pc) + 1'b1)));

  p_we_with_en_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  p_single_write_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

endmodule

bind bus_seq_core bus_seq_core_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ctrl   (ctrl),
  .state  (state),
  .pc     (pc),
  .mar    (mar),
  .cc     (cc),
  .mem_en (mem_en),
  .mem_we (mem_we)
);

// File: tb/bus_seq_core_bench.sv
module bus_seq_core_bench;

  localparam int          CLK_PERIOD = 10;
  localparam int          W          = 16;
  localparam logic [15:0] START      = 16'h0010;
  localparam int          MEM_AW     = 6;
  localparam int          N_VEC      = 16;

  // program, cycles per instruction, flags after it, optional memory check
  localparam logic [15:0] PROG [N_VEC] = '{
    16'h1225, 16'h1479, 16'h1642, 16'h7643, 16'h747E, 16'h18A2, 16'h6A43, 16'h6C7E,
    16'h6E5F, 16'h7D7F, 16'h1186, 16'h71C0, 16'h1024, 16'hF000, 16'h126F, 16'h7201};
  localparam int CYC [N_VEC] = '{5, 5, 5, 7, 7, 5, 7, 7, 7, 7, 5, 7, 5, 4, 5, 7};
  localparam logic [2:0] CCX [N_VEC] = '{
    3'b001, 3'b100, 3'b001, 3'b001, 3'b001, 3'b010, 3'b001, 3'b100,
    3'b010, 3'b010, 3'b100, 3'b100, 3'b010, 3'b010, 3'b001, 3'b001};
  localparam logic CHK [N_VEC] = '{0, 0, 0, 1, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 1};
  localparam logic [5:0] CADR [N_VEC] = '{
    6'd0, 6'd0, 6'd0, 6'd8, 6'd3, 6'd0, 6'd0, 6'd0,
    6'd0, 6'd2, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd1};
  localparam logic [15:0] CVAL [N_VEC] = '{
    16'h0, 16'h0, 16'h0, 16'h0003, 16'hFFFE, 16'h0, 16'h0, 16'h0,
    16'h0, 16'hFFFE, 16'h0, 16'hFFFC, 16'h0, 16'h0, 16'h0, 16'h0014};
  localparam string REQ [N_VEC] = '{
    "R4", "R4", "R4", "R6", "R6", "R4", "R7", "R7",
    "R7", "R6", "R4", "R6", "R9", "R8", "R4", "R6"};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] mem_rdata;
  logic         mem_en, mem_we, fetch_start;
  logic [W-1:0] mem_addr, mem_wdata;
  logic [2:0]   cc_nzp;

  logic [15:0]  mem [1 << MEM_AW];
  logic         ld_en = 1'b0;
  logic [5:0]   ld_addr = '0;
  logic [15:0]  ld_data = '0;
  int           wr_cnt = 0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_seq_core #(.W(W), .START_ADDR(START)) u_bus_seq_core (
    .clk         (clk),
    .rst         (rst),
    .mem_rdata   (mem_rdata),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .cc_nzp      (cc_nzp),
    .fetch_start (fetch_start)
  );

  always_ff @(posedge clk) begin
    if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (mem_en && mem_we) begin
      mem[mem_addr[MEM_AW-1:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  assign mem_rdata = mem[mem_addr[MEM_AW-1:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_word(input logic [5:0] a, input logic [15:0] d);
    ld_en   = 1'b1;
    ld_addr = a;
    ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // count cycles up to the next fetch start; checks the fetch address
  task automatic run_instr(input logic [15:0] pc_exp, input string req, output int cyc);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        check(mem_en && !mem_we && (mem_addr == pc_exp), "R2", "fetch address",
              mem_addr, pc_exp);
      end
    end while (!fetch_start && n < 50);
    if (n >= 50) check(1'b0, req, "instruction hung", 16'(n), 16'd0);
    cyc = n;
  endtask

  initial begin
    int cyc;
    int w0;
    for (int a = 0; a < (1 << MEM_AW); a++) load_word(6'(a), 16'h0000);
    for (int i = 0; i < N_VEC; i++) load_word(6'(START + 16'(i)), PROG[i]);
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1: state right after reset
    check(fetch_start == 1'b1, "R1", "fetch_start after reset", 16'(fetch_start), 16'd1);
    check(cc_nzp == 3'b010, "R1", "flags after reset", 16'(cc_nzp), 16'h2);
    check(mem_en == 1'b0, "R1", "mem_en after reset", 16'(mem_en), 16'd0);

    for (int i = 0; i < N_VEC; i++) begin
      w0 = wr_cnt;
      run_instr(START + 16'(i), REQ[i], cyc);
      check(cyc == CYC[i], REQ[i], $sformatf("cycles of instr %0d", i), 16'(cyc), 16'(CYC[i]));
      check(cc_nzp == CCX[i], "R5", $sformatf("flags after instr %0d", i),
            16'(cc_nzp), 16'(CCX[i]));
      check((wr_cnt - w0) == int'(CHK[i]), "R10", $sformatf("writes in instr %0d", i),
            16'(wr_cnt - w0), 16'(CHK[i]));
      if (CHK[i]) begin
        check(mem[CADR[i]] == CVAL[i], REQ[i], $sformatf("memory after instr %0d", i),
              mem[CADR[i]], CVAL[i]);
      end
    end

    // R8: unknown opcode left address 0 alone
    check(mem[0] == 16'hFFFC, "R8", "memory kept across unknown opcode", mem[0], 16'hFFFC);

    // R1: reset in mid-instruction, then store R1 (must be zero) to address 9
    rst = 1'b1;
    load_word(6'(START), 16'h7209);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(fetch_start == 1'b1, "R1", "fetch after mid reset", 16'(fetch_start), 16'd1);
    check(cc_nzp == 3'b010, "R1", "flags after mid reset", 16'(cc_nzp), 16'h2);
    run_instr(START, "R1", cyc);
    check(cyc == 7, "R6", "store cycles after reset", 16'(cyc), 16'd7);
    check(mem[9] == 16'h0000, "R1", "register cleared by reset", mem[9], 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule